// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block sits on the memory side of a synchronous DRAM and turns an accepted READ or WRITE command into the column addresses of its burst, one per clock. It also times when read data becomes valid. A mode word that is loaded separately sets four things: the burst length, the order of beats (sequential or interleaved), the read latency, and whether writes are cut to a single beat. Every burst stays inside the block of columns that is aligned to the burst length. Only the low column bits move during a burst, and they wrap within that block.

A command strobe carries a read/write flag and a start column. The beat sequence starts on the clock edge that samples the command. The block drives a column-valid flag and a last-beat flag alongside the address. For reads, a delay line raises a read-data-valid flag once per read beat, a programmed number of clocks after that beat was issued. A command that arrives while a burst is running cuts that burst short and takes over. A mode load is accepted only when the block is quiet.

Top module: `burst_col_seq`

## Requirements
- R1: Mode bits [2:0] select the burst length: 000 gives 1 beat, 001 gives 2, 010 gives 4 and 011 gives 8. Every other code gives 1 beat.
- R2: With mode bit 3 = 0 (sequential order), beat i carries the low log2(length) column bits (start + i) modulo the length. All column bits above them equal the start column.
- R3: With mode bit 3 = 1 (interleaved order), beat i carries start XOR i on the low log2(length) column bits. All column bits above them equal the start column.
- R4: When a command is sampled at edge n, beat k is driven after edge n+k with col_valid high. last_beat is high only on the final beat, and col_valid is low after the burst ends.
- R5: Mode bits [6:4] select the read latency L: 011 gives 3, and every other code gives 2. For a read sampled at edge n, rd_data_valid is high after edges n+L through n+L+length-1 and low otherwise.
- R6: With mode bit 9 = 1, every write has exactly one beat while reads keep the programmed length. With bit 9 = 0, writes use the programmed length.
- R7: Write beats never raise rd_data_valid.
- R8: A command sampled during a burst ends that burst at once. Its own beat 0 follows on the next clock, and read beats already issued still produce their rd_data_valid cycles.
- R9: A mode load is ignored if, at the edge that samples it, beats remain to issue, a command is sampled, or read data is still pending. The previous mode then stays in force.
- R10: Reset clears col_valid, last_beat and rd_data_valid and sets the mode to the value of an all-zero mode word (1 beat, sequential, latency 2, full-length writes).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, sampled on the rising edge |
| cmd_is_write | input | 1 | 1 = write command, 0 = read command |
| cmd_col | input | COL_W | Start column of the burst |
| mode_load | input | 1 | Mode word load strobe |
| mode_word | input | MODE_W | Mode word (length [2:0], order [3], latency [6:4], single-beat writes [9]) |
| col_addr | output | COL_W | Column address of the current beat |
| col_valid | output | 1 | A beat is being driven this cycle |
| last_beat | output | 1 | The current beat is the last one of its burst |
| rd_data_valid | output | 1 | Read data is valid this cycle |

## Verification
The assertions check on every cycle that a sampled command appears as beat 0 on the next clock with its own start column. They also check that an unfinished burst keeps driving beats, that the column bits above the wrap field stay put during a burst, and that last_beat never shows without col_valid and always ends the burst. The exact wrap order for each length, start offset and ordering, the latency of rd_data_valid and its beat count, single-beat writes, truncation, and the refusal of a mode load while busy depend on the loaded mode and on command history. These show up only in the bench's vector table and directed scenarios, where expected sequences are written out by hand.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
   localparam int MAX_BEATS = 8;
   localparam int OFS_W     = $clog2(MAX_BEATS);
   localparam int LEN_W     = OFS_W + 1;
   localparam int MODE_MIN  = 10;

   typedef struct packed {
      logic [LEN_W-1:0] beats;   // 1, 2, 4 or 8
      logic             ilv;     // interleaved order
      logic [1:0]       lat;     // 2 or 3
      logic             wr_one;  // writes are single beat
   } bcs_mode_t;

   function automatic bcs_mode_t bcs_decode(input logic [MODE_MIN-1:0] w);
      bcs_mode_t m;
      case (w[2:0])
         3'b001:  m.beats = LEN_W'(2);
         3'b010:  m.beats = LEN_W'(4);
         3'b011:  m.beats = LEN_W'(8);
         default: m.beats = LEN_W'(1);
      endcase
      m.ilv    = w[3];
      m.lat    = (w[6:4] == 3'b011) ? 2'd3 : 2'd2;
      m.wr_one = w[9];
      return m;
   endfunction
endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
   import bcs_pkg::*;
#(
   parameter int MODE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [MODE_W-1:0] word,
   output bcs_mode_t         cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= bcs_decode('0);
      end else if (load_en) begin
         cfg <= bcs_decode(word[MODE_MIN-1:0]);
      end
   end
endmodule

// File: rtl/bcs_beat_ctrl.sv
module bcs_beat_ctrl
   import bcs_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_is_write,
   input  logic [COL_W-1:0] cmd_col,
   input  bcs_mode_t        cfg,
   output logic             active,
   output logic             last,
   output logic             is_rd,
   output logic             ilv,
   output logic [COL_W-1:0] start,
   output logic [OFS_W-1:0] idx,
   output logic [LEN_W-1:0] len
);
   logic             is_wr;
   logic [LEN_W-1:0] len_m1;
   logic [LEN_W-1:0] cmd_len;

   assign cmd_len = (cmd_is_write && cfg.wr_one) ? LEN_W'(1) : cfg.beats;
   assign len_m1  = len - LEN_W'(1);
   assign last    = active && ({1'b0, idx} == len_m1);
   assign is_rd   = active && !is_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         is_wr  <= 1'b0;
         ilv    <= 1'b0;
         start  <= '0;
         idx    <= '0;
         len    <= LEN_W'(1);
      end else if (cmd_valid) begin
         active <= 1'b1;
         is_wr  <= cmd_is_write;
         ilv    <= cfg.ilv;
         start  <= cmd_col;
         idx    <= '0;
         len    <= cmd_len;
      end else if (active) begin
         if (last) begin
            active <= 1'b0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/bcs_addr_gen.sv
module bcs_addr_gen
   import bcs_pkg::*;
#(
   parameter int COL_W = 10
) (
   input  logic             ilv,
   input  logic [COL_W-1:0] start,
   input  logic [OFS_W-1:0] idx,
   input  logic [LEN_W-1:0] len,
   output logic [COL_W-1:0] col
);
   logic [OFS_W-1:0] base;
   logic [OFS_W-1:0] seq_ofs;
   logic [OFS_W-1:0] xor_ofs;
   logic [OFS_W-1:0] pick;
   logic [LEN_W-1:0] len_m1;

   assign base    = start[OFS_W-1:0];
   assign seq_ofs = base + idx;
   assign xor_ofs = base ^ idx;
   assign pick    = ilv ? xor_ofs : seq_ofs;
   assign len_m1  = len - LEN_W'(1);

   generate
      for (genvar b = 0; b < OFS_W; b++) begin : g_bit
         assign col[b] = len_m1[b] ? pick[b] : base[b];
      end
      if (COL_W > OFS_W) begin : g_upper
         assign col[COL_W-1:OFS_W] = start[COL_W-1:OFS_W];
      end
   endgenerate
endmodule

// File: rtl/bcs_rdv_pipe.sv
module bcs_rdv_pipe #(
   parameter int LAT_MAX = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       issue,
   input  logic [1:0] lat,
   output logic       rdv,
   output logic       pending
);
   logic [LAT_MAX-1:0] stg;

   generate
      for (genvar j = 0; j < LAT_MAX; j++) begin : g_stage
         if (j == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= 1'b0;
               else        stg[0] <= issue;
            end
         end else begin : g_tail
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[j] <= 1'b0;
               else        stg[j] <= stg[j-1];
            end
         end
      end
   endgenerate

   assign rdv     = stg[int'(lat) - 1];
   assign pending = issue || (|stg);
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
   import bcs_pkg::*;
#(
   parameter int COL_W   = 10,
   parameter int MODE_W  = 10,
   parameter int LAT_MAX = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_is_write,
   input  logic [COL_W-1:0]  cmd_col,
   input  logic              mode_load,
   input  logic [MODE_W-1:0] mode_word,
   output logic [COL_W-1:0]  col_addr,
   output logic              col_valid,
   output logic              last_beat,
   output logic              rd_data_valid
);
   generate
      if (COL_W < OFS_W) begin : g_bad_col
         $error("COL_W must cover the burst offset field");
      end
      if (MODE_W < MODE_MIN) begin : g_bad_mode
         $error("MODE_W must hold bits 0 to 9");
      end
      if (LAT_MAX < 3) begin : g_bad_lat
         $error("LAT_MAX must be at least 3");
      end
   endgenerate

   bcs_mode_t        cfg;
   logic             active, last, is_rd, ilv, pending, load_ok;
   logic [COL_W-1:0] start;
   logic [OFS_W-1:0] idx;
   logic [LEN_W-1:0] len;

   assign load_ok = mode_load && !cmd_valid && !(active && !last) && !pending;

   bcs_mode_reg #(.MODE_W(MODE_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .load_en(load_ok), .word(mode_word), .cfg(cfg)
   );

   bcs_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write),
      .cmd_col(cmd_col), .cfg(cfg), .active(active), .last(last), .is_rd(is_rd),
      .ilv(ilv), .start(start), .idx(idx), .len(len)
   );

   bcs_addr_gen #(.COL_W(COL_W)) u_addr (
      .ilv(ilv), .start(start), .idx(idx), .len(len), .col(col_addr)
   );

   bcs_rdv_pipe #(.LAT_MAX(LAT_MAX)) u_rdv (
      .clk(clk), .rst_n(rst_n), .issue(is_rd), .lat(cfg.lat),
      .rdv(rd_data_valid), .pending(pending)
   );

   assign col_valid = active;
   assign last_beat = last;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk
   import bcs_pkg::*;
#(
   parameter int COL_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_valid,
   input logic [COL_W-1:0] cmd_col,
   input logic [COL_W-1:0] col_addr,
   input logic             col_valid,
   input logic             last_beat
);
   // R4
   cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> (col_valid && col_addr == $past(cmd_col)));

   // R4
   last_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_beat |-> col_valid);

   // R4
   burst_keeps_going_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && !last_beat && !cmd_valid) |=> col_valid);

   // R4
   burst_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (last_beat && !cmd_valid) |=> !col_valid);

   // R2
   upper_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (col_valid && !last_beat && !cmd_valid) |=>
         (col_addr[COL_W-1:OFS_W] == $past(col_addr[COL_W-1:OFS_W])));
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_col(cmd_col),
   .col_addr(col_addr), .col_valid(col_valid), .last_beat(last_beat)
);

// File: tb/tb_burst_col_seq.sv
module tb_burst_col_seq;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;

   // Vector table: mode word, write flag, start column, expected beats,
   // expected latency, expected low three column bits per beat (beat i in nibble i).
   // 0: R2 R5 sequential 8 beats, latency 2
   // 1: R3 R5 interleaved 8 beats, latency 3
   // 2: R2 R5 sequential 4 beats, latency 3
   // 3: R3 R7 interleaved 4-beat write
   // 4: R1 R2 sequential 2 beats
   // 5: R6 write cut to one beat
   // 6: R1 R5 reserved length and latency codes
   // 7: R6 read keeps its length while writes are single beat
   localparam logic [9:0]  V_MODE [NV] = '{10'h023, 10'h03B, 10'h032, 10'h02A,
                                           10'h021, 10'h223, 10'h005, 10'h222};
   localparam logic        V_WR   [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
   localparam logic [9:0]  V_COL  [NV] = '{10'h0D5, 10'h0D5, 10'h3FE, 10'h013,
                                           10'h001, 10'h005, 10'h007, 10'h00B};
   localparam int          V_LEN  [NV] = '{8, 8, 4, 4, 2, 1, 1, 4};
   localparam int          V_LAT  [NV] = '{2, 3, 3, 2, 2, 2, 2, 2};
   localparam logic [31:0] V_SEQ  [NV] = '{32'h43210765, 32'h23016745, 32'h00005476,
                                           32'h00000123, 32'h00000001, 32'h00000005,
                                           32'h00000007, 32'h00002103};

   logic       clk = 1'b0;
   logic       rst_n;
   logic       cmd_valid, cmd_is_write, mode_load;
   logic [9:0] cmd_col, mode_word;
   logic [9:0] col_addr;
   logic       col_valid, last_beat, rd_data_valid;

   int checks = 0;
   int errors = 0;

   burst_col_seq dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write),
      .cmd_col(cmd_col), .mode_load(mode_load), .mode_word(mode_word),
      .col_addr(col_addr), .col_valid(col_valid), .last_beat(last_beat),
      .rd_data_valid(rd_data_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic load_mode(input logic [9:0] w);
      mode_load = 1'b1;
      mode_word = w;
      @(negedge clk);
      mode_load = 1'b0;
   endtask

   task automatic issue(input logic wr, input logic [9:0] col);
      cmd_valid    = 1'b1;
      cmd_is_write = wr;
      cmd_col      = col;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int cnt_v, cnt_r;
      logic [9:0] exp_a;
      rst_n = 1'b0; cmd_valid = 1'b0; cmd_is_write = 1'b0; cmd_col = '0;
      mode_load = 1'b0; mode_word = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      chk(!col_valid && !last_beat && !rd_data_valid, "R10", "outputs idle after reset",
          {col_valid, last_beat, rd_data_valid}, 0);
      // R10 reset mode: one beat, latency 2
      issue(1'b0, 10'h2A5);
      cnt_v = 0; cnt_r = 0;
      for (int k = 0; k < 6; k++) begin
         if (col_valid) cnt_v++;
         if (k == 0) chk(col_addr == 10'h2A5, "R10", "reset mode beat 0 column", col_addr, 10'h2A5);
         chk(rd_data_valid == (k == 2), "R10", "reset mode latency", rd_data_valid, (k == 2));
         @(negedge clk);
      end
      chk(cnt_v == 1, "R10", "reset mode beat count", cnt_v, 1);

      // Vector table
      for (int v = 0; v < NV; v++) begin
         load_mode(V_MODE[v]);
         repeat (2) @(negedge clk);
         issue(V_WR[v], V_COL[v]);
         for (int k = 0; k < V_LEN[v] + V_LAT[v] + 3; k++) begin
            // R4 beat presence and last beat
            chk(col_valid == (k < V_LEN[v]), "R1/R4/R6", $sformatf("vec %0d col_valid k=%0d", v, k),
                col_valid, (k < V_LEN[v]));
            chk(last_beat == (k == V_LEN[v] - 1), "R4", $sformatf("vec %0d last_beat k=%0d", v, k),
                last_beat, (k == V_LEN[v] - 1));
            if (k < V_LEN[v]) begin
               exp_a = {V_COL[v][9:3], V_SEQ[v][4*k +: 3]};
               chk(col_addr == exp_a, "R2/R3", $sformatf("vec %0d column k=%0d", v, k),
                   col_addr, exp_a);
            end
            // R5 R7 read data valid window
            chk(rd_data_valid == (!V_WR[v] && k >= V_LAT[v] && k < V_LAT[v] + V_LEN[v]),
                "R5/R7", $sformatf("vec %0d rd_data_valid k=%0d", v, k), rd_data_valid,
                (!V_WR[v] && k >= V_LAT[v] && k < V_LAT[v] + V_LEN[v]));
            @(negedge clk);
         end
      end

      // R8 truncation: 8-beat read cut after 3 beats by an 8-beat write
      load_mode(10'h023);
      repeat (2) @(negedge clk);
      issue(1'b0, 10'h000);
      cnt_v = 0; cnt_r = 0;
      for (int k = 0; k < 15; k++) begin
         if (col_valid) cnt_v++;
         if (rd_data_valid) cnt_r++;
         if (k < 3) exp_a = 10'(k);
         else       exp_a = 10'h100 | 10'((4 + k - 3) & 7);
         if (k < 11) chk(col_addr == exp_a, "R8", $sformatf("truncation column k=%0d", k), col_addr, exp_a);
         if (k == 10) chk(last_beat, "R8", "new burst last beat", last_beat, 1);
         if (k == 2) begin
            cmd_valid = 1'b1; cmd_is_write = 1'b1; cmd_col = 10'h104;
         end
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      chk(cnt_v == 11, "R8", "beats across truncation", cnt_v, 11);
      chk(cnt_r == 3, "R8", "read data cycles of truncated read", cnt_r, 3);

      // R9 mode load during a burst is ignored
      issue(1'b0, 10'h010);
      mode_load = 1'b1; mode_word = 10'h000;
      @(negedge clk);
      mode_load = 1'b0;
      repeat (12) @(negedge clk);
      issue(1'b0, 10'h018);
      cnt_v = 0;
      for (int k = 0; k < 12; k++) begin
         if (col_valid) cnt_v++;
         @(negedge clk);
      end
      chk(cnt_v == 8, "R9", "burst length after refused load", cnt_v, 8);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule